// File: doc/BRIEF.md
# Double-Buffered Time-Slot Routing Table Swapper

This block keeps the time-slot routing tables of two TDM ports, called a and b, in both directions, four tables in all. Every table has two banks of equal depth. One bank serves lookups and the other is the shadow. Software rewrites the shadow bank through a byte-addressed write port while traffic keeps running on the active bank. It then raises that table's swap request bit. The block exchanges the two banks on the next frame-sync edge of that table and clears the request. A frame therefore never mixes entries from the old and new tables.

Each table has its own lookup port with one cycle of registered latency. Each table also has its own frame-sync input, so the four tables swap independently of one another. Software can poll the request bits to find out when a new table is in service. The bank-select bits can be read as well. The block does not decode the meaning of the entries, and it does not move any channel data.

Top module: `rt_bank_swapper`

## Requirements
- R1: After reset, every request bit reads 0, every table uses bank 0 for lookups, every stored entry is 0, and every lookup output is 0.
- R2: The write byte address is decoded as follows. Bit 10 selects the direction: 1 means receive and 0 means transmit. Bits 8:7 select the region, with bit 8 giving the bank and bit 7 giving the port (0 = a, 1 = b). Bits 6:1 select the slot. Bit 0 is ignored. A write with bit 9 set is discarded.
- R3: A write to the bank that is currently active for its table is discarded. A write to the shadow bank does not change what that table's lookup returns.
- R4: Table index t is mapped as 0 = receive-a, 1 = transmit-a, 2 = receive-b, 3 = transmit-b. A pulse on set bit t makes request bit t read 1 from the next cycle onward. The bit stays 1 until its swap takes place.
- R5: While request bit t is 1, a rising edge on sync input t exchanges the roles of the two banks of table t and clears request bit t. Both changes are visible right after the clock edge that samples the sync edge.
- R6: A sync rising edge on a table with no pending request changes nothing. A sync input held high swaps at most once, and only on its rising edge.
- R7: The four tables are fully independent. Requests, syncs and writes for one table never change the bank select, the request bit or the lookups of another table.
- R8: Lookup output t returns the entry of table t at the presented slot, taken from the active bank, one clock after the slot is presented. The bank select is sampled in the same cycle as the slot, so a lookup presented in the cycle of a swap still returns the old bank.
- R9: If a set pulse arrives in the same cycle as a swap of that table, the swap takes place and the request bit stays 1, which asks for another swap at the next sync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the table store |
| wr_addr_i | input | 11 | Byte address of the written entry |
| wr_data_i | input | 16 | Entry value to write |
| req_set_i | input | 4 | Per-table pulse that sets the swap request |
| sync_i | input | 4 | Per-table frame-sync input |
| req_o | output | 4 | Pending swap request bits |
| bank_o | output | 4 | Active bank per table |
| lk_slot_i | input | 4x6 | Per-table lookup slot index |
| lk_data_o | output | 4x16 | Per-table registered lookup result |

## Verification
If a bank-select bit is corrupted, whole lookup sweeps show the wrong pattern, either stale zeros or the shadow contents. The bench checks this one cycle after each slot is presented, for all 64 slots of all four tables. A request bit that clears early or late shows up on the req_o and bank_o ports at the first negative edge after the sync edge. If the write decode mixes up tables, banks or the discard rules, an entry appears in the wrong table after the next swap, and the post-swap sweeps expose it. The same-cycle cases are probed in the exact cycle they occur: a lookup during a swap, and a set pulse during a swap.

// File: rtl/rt_swap_pkg.sv
package rt_swap_pkg;
   // Number of routing tables: two ports times two directions.
   localparam int NTAB = 4;

   // Table numbering. Bit 1 selects the port, bit 0 selects transmit.
   localparam logic [1:0] TBL_RXA = 2'd0;
   localparam logic [1:0] TBL_TXA = 2'd1;
   localparam logic [1:0] TBL_RXB = 2'd2;
   localparam logic [1:0] TBL_TXB = 2'd3;

   // Builds a table index from its port and direction.
   function automatic logic [1:0] tbl_index(input logic port_b, input logic is_tx);
      return {port_b, is_tx};
   endfunction

   // Decoded form of one write address.
   typedef struct packed {
      logic       valid;
      logic [1:0] tbl;
      logic       bank;
   } wr_target_t;
endpackage

// File: rtl/rt_addr_decode.sv
module rt_addr_decode
   import rt_swap_pkg::*;
#(
   parameter int SLOTS   = 64,
   parameter int ENTRY_W = 16,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int EB     = $clog2(ENTRY_W / 8),
   localparam int LB     = SLOT_W + EB,
   localparam int ADDR_W = LB + 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   output wr_target_t        tgt_o,
   output logic [SLOT_W-1:0] slot_o
);
   // Address layout, from the top bit down:
   //   direction (1 = rx), reserved (must be 0), bank, port, slot, byte lane.
   logic is_rx;
   logic port_b;

   assign is_rx      = addr_i[LB+3];
   assign port_b     = addr_i[LB];
   assign tgt_o.valid = ~addr_i[LB+2];
   assign tgt_o.bank  = addr_i[LB+1];
   assign tgt_o.tbl   = tbl_index(port_b, ~is_rx);
   assign slot_o      = addr_i[LB-1:EB];
endmodule

// File: rtl/rt_swap_ctrl.sv
module rt_swap_ctrl #(
   parameter bit SYNC_FALL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_i,
   input  logic req_set_i,
   output logic req_o,
   output logic bank_o
);
   logic sync_q;
   logic sy_edge;

   // The parameter picks which sync edge marks the frame boundary.
   generate
      if (SYNC_FALL) begin : g_fall
         assign sy_edge = sync_q & ~sync_i;
      end else begin : g_rise
         assign sy_edge = ~sync_q & sync_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= 1'b0;
         req_o  <= 1'b0;
         bank_o <= 1'b0;
      end else begin
         sync_q <= sync_i;
         if (sy_edge && req_o) begin
            bank_o <= ~bank_o;
            // A set pulse in the swap cycle leaves a fresh request pending.
            req_o  <= req_set_i;
         end else if (req_set_i) begin
            req_o <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/rt_table_bank.sv
module rt_table_bank #(
   parameter int SLOTS   = 64,
   parameter int ENTRY_W = 16,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic               wr_bank_i,
   input  logic [SLOT_W-1:0]  wr_slot_i,
   input  logic [ENTRY_W-1:0] wr_data_i,
   input  logic               rd_bank_i,
   input  logic [SLOT_W-1:0]  rd_slot_i,
   output logic [ENTRY_W-1:0] rd_data_o
);
   logic [1:0][ENTRY_W-1:0] rd_word;

   // One storage array per bank. Each bank is read continuously at the lookup slot.
   generate
      for (genvar b = 0; b < 2; b++) begin : g_bank
         logic [ENTRY_W-1:0] mem [SLOTS];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
            end else if (wr_en_i && (wr_bank_i == 1'(b))) begin
               mem[wr_slot_i] <= wr_data_i;
            end
         end

         assign rd_word[b] = mem[rd_slot_i];
      end
   endgenerate

   // The bank select and the slot are sampled together in the same cycle.
   always_ff @(posedge clk) begin
      if (!rst_n) rd_data_o <= '0;
      else        rd_data_o <= rd_word[rd_bank_i];
   end
endmodule

// File: rtl/rt_bank_swapper.sv
module rt_bank_swapper
   import rt_swap_pkg::*;
#(
   parameter int SLOTS     = 64,
   parameter int ENTRY_W   = 16,
   parameter bit SYNC_FALL = 1'b0,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int ADDR_W = SLOT_W + $clog2(ENTRY_W / 8) + 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en_i,
   input  logic [ADDR_W-1:0]             wr_addr_i,
   input  logic [ENTRY_W-1:0]            wr_data_i,
   input  logic [NTAB-1:0]               req_set_i,
   input  logic [NTAB-1:0]               sync_i,
   output logic [NTAB-1:0]               req_o,
   output logic [NTAB-1:0]               bank_o,
   input  logic [NTAB-1:0][SLOT_W-1:0]   lk_slot_i,
   output logic [NTAB-1:0][ENTRY_W-1:0]  lk_data_o
);
   // Elaboration-time parameter checks.
   generate
      if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
         $error("SLOTS must be a power of two and at least 2");
      end
      if (ENTRY_W < 8 || (ENTRY_W % 8) != 0 ||
          ((ENTRY_W / 8) & ((ENTRY_W / 8) - 1)) != 0) begin : g_bad_width
         $error("ENTRY_W must be a power-of-two number of bytes");
      end
   endgenerate

   wr_target_t        tgt;
   logic [SLOT_W-1:0] wr_slot;

   rt_addr_decode #(
      .SLOTS   (SLOTS),
      .ENTRY_W (ENTRY_W)
   ) u_dec (
      .addr_i (wr_addr_i),
      .tgt_o  (tgt),
      .slot_o (wr_slot)
   );

   generate
      for (genvar t = 0; t < NTAB; t++) begin : g_tab
         logic we;

         // Only the shadow bank of the addressed table accepts writes.
         assign we = wr_en_i && tgt.valid && (tgt.tbl == 2'(t)) &&
                     (tgt.bank != bank_o[t]);

         rt_swap_ctrl #(
            .SYNC_FALL (SYNC_FALL)
         ) u_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .sync_i    (sync_i[t]),
            .req_set_i (req_set_i[t]),
            .req_o     (req_o[t]),
            .bank_o    (bank_o[t])
         );

         rt_table_bank #(
            .SLOTS   (SLOTS),
            .ENTRY_W (ENTRY_W)
         ) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (we),
            .wr_bank_i (tgt.bank),
            .wr_slot_i (wr_slot),
            .wr_data_i (wr_data_i),
            .rd_bank_i (bank_o[t]),
            .rd_slot_i (lk_slot_i[t]),
            .rd_data_o (lk_data_o[t])
         );
      end
   endgenerate
endmodule

// File: rtl/rt_bank_swapper_chk.sv
module rt_bank_swapper_chk #(
   parameter int NT        = 4,
   parameter bit SYNC_FALL = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic [NT-1:0] sync_i,
   input logic [NT-1:0] req_set_i,
   input logic [NT-1:0] req_o,
   input logic [NT-1:0] bank_o
);
   logic [NT-1:0] sync_prev;
   logic [NT-1:0] sy_edge;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_prev <= '0;
      else        sync_prev <= sync_i;
   end

   assign sy_edge = SYNC_FALL ? (sync_prev & ~sync_i) : (~sync_prev & sync_i);

   generate
      for (genvar t = 0; t < NT; t++) begin : g_t
         AST_SET_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            req_set_i[t] |=> req_o[t]); // R4

         AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (req_o[t] && !sy_edge[t]) |=> req_o[t]); // R4

         AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req_o[t]) |-> $past(req_set_i[t])); // R4

         AST_SWAP_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
            (req_o[t] && sy_edge[t]) |=> (bank_o[t] != $past(bank_o[t]))); // R5

         AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (req_o[t] && sy_edge[t] && !req_set_i[t]) |=> !req_o[t]); // R5

         AST_NO_SPURIOUS_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
            !(req_o[t] && sy_edge[t]) |=> $stable(bank_o[t])); // R6

         AST_SET_DURING_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
            (req_o[t] && sy_edge[t] && req_set_i[t]) |=> req_o[t]); // R9
      end
   endgenerate
endmodule

bind rt_bank_swapper rt_bank_swapper_chk #(
   .NT        (rt_swap_pkg::NTAB),
   .SYNC_FALL (SYNC_FALL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sync_i    (sync_i),
   .req_set_i (req_set_i),
   .req_o     (req_o),
   .bank_o    (bank_o)
);

// File: tb/sim_rt_bank_swapper.sv
`timescale 1ns/1ps
module sim_rt_bank_swapper;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [10:0]       wr_addr = '0;
   logic [15:0]       wr_data = '0;
   logic [3:0]        req_set = '0;
   logic [3:0]        sync = '0;
   logic [3:0]        req;
   logic [3:0]        bank;
   logic [3:0][5:0]   lk_slot = '0;
   logic [3:0][15:0]  lk_data;

   int total = 0;
   int fails = 0;

   logic [15:0] exp_m [4][2][64];
   logic        exp_bank [4];
   logic        exp_req [4];

   always #2.5 clk = ~clk;

   rt_bank_swapper u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .req_set_i (req_set),
      .sync_i    (sync),
      .req_o     (req),
      .bank_o    (bank),
      .lk_slot_i (lk_slot),
      .lk_data_o (lk_data)
   );

   function automatic logic [15:0] pat(int k, int t, int s);
      return 16'(k * 4099 + t * 257 + s * 31 + 1);
   endfunction

   task automatic chk(string rq, logic [15:0] act, logic [15:0] expv);
      total++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", rq, act, expv);
      end
   endtask

   task automatic chk_state(string rq);
      for (int t = 0; t < 4; t++) begin
         chk(rq, 16'(req[t]), 16'(exp_req[t]));
         chk(rq, 16'(bank[t]), 16'(exp_bank[t]));
      end
   endtask

   // Write through the R2 address map. Bit 0 is set on odd slots to show that it is ignored.
   task automatic wr(int t, int b, int s, logic [15:0] d, bit bad);
      wr_addr = 11'((t[0] ? 0 : 1024) + (bad ? 512 : 0) + (b * 2 + t / 2) * 128 + s * 2 + (s % 2));
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      if (!bad && (1'(b) != exp_bank[t])) exp_m[t][b][s] = d;
   endtask

   task automatic sweep(string rq);
      for (int s = 0; s < 64; s++) begin
         for (int t = 0; t < 4; t++) lk_slot[t] = 6'(s);
         @(negedge clk);
         for (int t = 0; t < 4; t++) chk(rq, lk_data[t], exp_m[t][exp_bank[t]][s]);
      end
   endtask

   task automatic set_req(logic [3:0] m);
      req_set = m;
      @(negedge clk);
      req_set = '0;
      for (int t = 0; t < 4; t++) if (m[t]) exp_req[t] = 1'b1;
   endtask

   task automatic pulse_sync(logic [3:0] m);
      sync = sync | m;
      @(negedge clk);
      for (int t = 0; t < 4; t++)
         if (m[t] && exp_req[t]) begin
            exp_bank[t] = ~exp_bank[t];
            exp_req[t]  = 1'b0;
         end
      sync = sync & ~m;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      for (int t = 0; t < 4; t++) begin
         exp_bank[t] = 1'b0;
         exp_req[t]  = 1'b0;
         for (int b = 0; b < 2; b++)
            for (int s = 0; s < 64; s++) exp_m[t][b][s] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk_state("R1");
      for (int t = 0; t < 4; t++) chk("R1", lk_data[t], 16'h0);
      sweep("R1");

      // R2, R3: fill every shadow bank; writes to the active bank and reserved addresses must vanish
      for (int t = 0; t < 4; t++)
         for (int s = 0; s < 64; s++) begin
            wr(t, 1, s, pat(1, t, s), 1'b0);
            wr(t, 0, s, pat(2, t, s), 1'b0);
         end
      for (int t = 0; t < 4; t++)
         for (int s = 0; s < 64; s += 5) wr(t, 1, s, pat(3, t, s), 1'b1);
      sweep("R3");

      // R4, R6, R7: request on tables 0 and 3 only; a sync on table 1 without a request does nothing
      set_req(4'b1001);
      chk_state("R4");
      pulse_sync(4'b0010);
      chk_state("R6");
      pulse_sync(4'b1001);
      chk_state("R5");
      sweep("R7");
      sweep("R2");

      // R3: table 0 now uses bank 1; writes to bank 1 drop, bank 0 is the shadow
      for (int s = 0; s < 64; s += 3) wr(0, 1, s, pat(4, 0, s), 1'b0);
      for (int s = 0; s < 64; s += 2) wr(0, 0, s, pat(5, 0, s), 1'b0);
      sweep("R3");

      // R6: a sync held high swaps once, only on its rising edge
      sync[2] = 1'b1;
      repeat (2) @(negedge clk);
      set_req(4'b0100);
      repeat (3) @(negedge clk);
      chk_state("R6");
      sync[2] = 1'b0;
      @(negedge clk);
      pulse_sync(4'b0100);
      chk_state("R6");
      sweep("R5");

      // R9: a set pulse in the swap cycle keeps the request pending
      set_req(4'b0001);
      req_set[0] = 1'b1;
      sync[0]    = 1'b1;
      @(negedge clk);
      req_set[0]  = 1'b0;
      sync[0]     = 1'b0;
      exp_bank[0] = ~exp_bank[0];
      exp_req[0]  = 1'b1;
      chk_state("R9");
      @(negedge clk);
      pulse_sync(4'b0001);
      chk_state("R9");
      sweep("R9");

      // R8: a lookup presented in the swap cycle returns the old bank, the next one the new
      wr(3, 0, 9, 16'hBEEF, 1'b0);
      set_req(4'b1000);
      lk_slot[3] = 6'd9;
      sync[3]    = 1'b1;
      @(negedge clk);
      chk("R8", lk_data[3], exp_m[3][1][9]);
      exp_bank[3] = 1'b0;
      exp_req[3]  = 1'b0;
      chk_state("R8");
      sync[3] = 1'b0;
      @(negedge clk);
      chk("R8", lk_data[3], 16'hBEEF);
      lk_slot[3] = 6'd10;
      #1;
      chk("R8", lk_data[3], 16'hBEEF);
      @(negedge clk);
      chk("R8", lk_data[3], exp_m[3][0][10]);
      sweep("R8");

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule